// File: doc/BRIEF.md
# SPI-to-WISHBONE Register Bridge

This block is an SPI slave that lets a host reach a space of sixteen 16-bit registers over four wires. Each transfer is framed by an active-low chip select and is 24 SCK bits long. The first bit chooses write or read. The next four bits pick the register. The bridge then runs a single 16-bit WISHBONE master cycle. For a read, that cycle starts in the middle of the frame. For a write, it starts once the data word has arrived.

The host learns whether the bus cycle finished through three ack bits that the bridge shifts back on MISO. If all three ack bits are zero, the slave behind the bus was too slow, and the host must repeat the transfer at once. A host that keeps chip select low past the 24th bit continues the transfer as a burst to the same register. A burst read repeats a 19-bit segment: three ack bits, then 16 data bits. A burst write repeats a 16-bit segment: 13 low data bits, then 3 trailing bits that carry the top of the following word.

All SPI pins are synchronized into the system clock, and the whole block runs on that clock. SCK must therefore be several times slower than `clk`.

Top module: `spi_wb_bridge`

## Requirements
- R1: Wire bit 0 of a frame selects the direction (1 = write, 0 = read), and wire bits 1 to 4 give the register address MSB first. A frame is 24 bits, and MOSI is sampled on rising SCK.
- R2: In a read frame, one WISHBONE read (`wb_we_o`=0) to the decoded address starts after wire bit 4 is sampled. MISO carries three ack bits in wire bits 5 to 7. Each ack bit is 1 once the bus ack has been seen before the falling SCK edge that launches that bit. Wire bits 8 to 23 then carry the read word MSB first.
- R3: If a read has not been acked when wire bit 8 is launched, the cycle is dropped and the data bits are all zero.
- R4: In a write frame, wire bits 5 to 20 carry the data MSB first. A WISHBONE write starts after wire bit 20 is sampled. MISO carries the ack bits in wire bits 21 to 23.
- R5: If a write has not been acked when wire bit 23 is sampled, it is dropped, the ack bits are all zero, and the register keeps its old value.
- R6: In a read frame, MOSI = 1 at wire bit 8 starts another read of the same address. With chip select still low after bit 23, each further 19-bit segment returns that read's three ack bits and then its data. With MOSI = 0 at bit 8, no read is started and the segment returns zeros.
- R7: With chip select still low after bit 23 of a write frame, each further 16-bit segment brings data bits 12..0. The written word is {previous three trailing bits, these 13 bits}. That write is issued after the 13th bit, and its ack bits ride on the segment's last three bits.
- R8: The three trailing bits of a write frame have no effect when chip select rises after them.
- R9: Raising chip select mid-frame resets the bit position, drops any open bus cycle, and starts no new cycle. The next frame decodes from wire bit 0.
- R10: MISO is 0 while chip select is high. While chip select is low, MISO changes only after a falling SCK edge.
- R11: `wb_stb_o` is only high with `wb_cyc_o`. Address, data and direction stay stable while a cycle waits for ack. The cycle ends in the clock after `wb_ack_i`.
- R12: While reset is held, and just after it, no bus cycle is active and MISO is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low chip select framing a transfer |
| spi_mosi | input | 1 | Host-to-bridge serial data |
| spi_miso | output | 1 | Bridge-to-host serial data (ack bits and read data) |
| wb_cyc_o | output | 1 | Bus cycle active |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Bus write enable |
| wb_adr_o | output | ADDR_W | Register address |
| wb_dat_o | output | DATA_W | Write data |
| wb_dat_i | input | DATA_W | Read data from the register file |
| wb_ack_i | input | 1 | Cycle acknowledge from the register file |

## Verification
The assertions assume that SCK and chip select change slowly compared with `clk`, so each SCK edge is seen as its own synchronized event. They also assume that the register file raises `wb_ack_i` for a single clock and only during an open cycle. The stimulus uses a half SCK period of ten clocks, changes chip select only while SCK is low, and drives a bus slave model that acks once after a set latency. Latencies of 0, 18, 38 and 200 clocks put the ack well inside the first, second or third ack window, or outside all of them, so every expected ack pattern has margin on both sides.

// File: rtl/spi_wb_pkg.sv
package spi_wb_pkg;

  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } dir_e;

  // Lane order of the synchronizer bank
  localparam int LANE_MOSI = 0;
  localparam int LANE_CSN  = 1;
  localparam int LANE_SCK  = 2;
  localparam int LANES     = 3;

endpackage

// File: rtl/spi_wb_sync.sv
module spi_wb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic cs_act,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s
);
  import spi_wb_pkg::*;

  localparam logic [LANES-1:0] RST_VAL = LANES'(1 << LANE_CSN);

  logic [LANES-1:0] raw;
  logic [LANES-1:0] synced;
  logic             sck_prev;

  assign raw[LANE_MOSI] = mosi;
  assign raw[LANE_CSN]  = cs_n;
  assign raw[LANE_SCK]  = sck;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[g]}};
      else     chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) sck_prev <= 1'b0;
    else     sck_prev <= synced[LANE_SCK];
  end

  assign cs_act   = ~synced[LANE_CSN];
  assign sck_rise =  synced[LANE_SCK] & ~sck_prev;
  assign sck_fall = ~synced[LANE_SCK] &  sck_prev;
  assign mosi_s   =  synced[LANE_MOSI];

endmodule

// File: rtl/spi_wb_frame.sv
module spi_wb_frame #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 16,
  parameter int ACK_BITS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              mosi_s,
  input  logic              ack_seen,
  input  logic [DATA_W-1:0] rdata,
  output logic              launch,
  output logic              launch_we,
  output logic [ADDR_W-1:0] launch_adr,
  output logic [DATA_W-1:0] launch_dat,
  output logic              drop,
  output logic              miso
);
  import spi_wb_pkg::*;

  localparam int HDR   = 1 + ADDR_W;
  localparam int FRAME = HDR + ACK_BITS + DATA_W;
  localparam int POS_W = $clog2(FRAME);

  // Positions are the index of the next wire bit to be sampled
  localparam logic [POS_W-1:0] P_ADR_LAST  = POS_W'(HDR - 1);
  localparam logic [POS_W-1:0] P_ACK_FIRST = POS_W'(HDR);
  localparam logic [POS_W-1:0] P_RD_DATA   = POS_W'(HDR + ACK_BITS);
  localparam logic [POS_W-1:0] P_WR_ISSUE  = POS_W'(HDR + DATA_W - 1);
  localparam logic [POS_W-1:0] P_WR_TAIL   = POS_W'(HDR + DATA_W);
  localparam logic [POS_W-1:0] P_LAST      = POS_W'(FRAME - 1);
  localparam logic [POS_W-1:0] P_RD_CONT   = POS_W'(HDR);
  localparam logic [POS_W-1:0] P_WR_CONT   = POS_W'(HDR + ACK_BITS);

  logic [POS_W-1:0]  pos_q;
  dir_e              dir_q;
  logic [ADDR_W-1:0] adr_q;
  logic [DATA_W-1:0] rx_q;
  logic [DATA_W-1:0] tx_q;
  logic              miso_q;
  logic              rise;
  logic              fall;
  logic [ADDR_W-1:0] adr_next;
  logic [DATA_W-1:0] word_next;

  assign rise      = sck_rise & cs_act;
  assign fall      = sck_fall & cs_act;
  assign adr_next  = {rx_q[ADDR_W-2:0], mosi_s};
  assign word_next = {rx_q[DATA_W-2:0], mosi_s};

  // Bus requests derived from the frame position
  always_comb begin
    launch     = 1'b0;
    launch_we  = 1'b0;
    launch_adr = adr_q;
    launch_dat = word_next;
    drop       = ~cs_act;
    if (rise) begin
      if (pos_q == P_ADR_LAST && dir_q == DIR_READ) begin
        launch     = 1'b1;
        launch_adr = adr_next;
      end
      if (pos_q == P_RD_DATA && dir_q == DIR_READ && mosi_s) begin
        launch = 1'b1;
      end
      if (pos_q == P_WR_ISSUE && dir_q == DIR_WRITE) begin
        launch    = 1'b1;
        launch_we = 1'b1;
      end
      if (pos_q == P_LAST && dir_q == DIR_WRITE) begin
        drop = 1'b1;
      end
    end
    if (fall && pos_q == P_RD_DATA && dir_q == DIR_READ) begin
      drop = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      dir_q  <= DIR_READ;
      adr_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      miso_q <= 1'b0;
    end else if (!cs_act) begin
      pos_q  <= '0;
      miso_q <= 1'b0;
    end else if (rise) begin
      rx_q <= word_next;
      if (pos_q == '0)        dir_q <= dir_e'(mosi_s);
      if (pos_q == P_ADR_LAST) adr_q <= adr_next;
      if (pos_q == P_LAST)
        pos_q <= (dir_q == DIR_WRITE) ? P_WR_CONT : P_RD_CONT;
      else
        pos_q <= pos_q + 1'b1;
    end else if (fall) begin
      if (dir_q == DIR_READ) begin
        if (pos_q >= P_ACK_FIRST && pos_q < P_RD_DATA) begin
          miso_q <= ack_seen;
        end else if (pos_q == P_RD_DATA) begin
          miso_q <= ack_seen & rdata[DATA_W-1];
          tx_q   <= ack_seen ? {rdata[DATA_W-2:0], 1'b0} : '0;
        end else if (pos_q > P_RD_DATA) begin
          miso_q <= tx_q[DATA_W-1];
          tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
        end else begin
          miso_q <= 1'b0;
        end
      end else begin
        miso_q <= (pos_q >= P_WR_TAIL) ? ack_seen : 1'b0;
      end
    end
  end

  assign miso = miso_q;

endmodule

// File: rtl/spi_wb_master.sv
module spi_wb_master #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic              launch_we,
  input  logic [ADDR_W-1:0] launch_adr,
  input  logic [DATA_W-1:0] launch_dat,
  input  logic              drop,
  input  logic              wb_ack_i,
  input  logic [DATA_W-1:0] wb_dat_i,
  output logic              wb_cyc_o,
  output logic              wb_stb_o,
  output logic              wb_we_o,
  output logic [ADDR_W-1:0] wb_adr_o,
  output logic [DATA_W-1:0] wb_dat_o,
  output logic              ack_seen,
  output logic [DATA_W-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_cyc_o <= 1'b0;
      wb_stb_o <= 1'b0;
      wb_we_o  <= 1'b0;
      wb_adr_o <= '0;
      wb_dat_o <= '0;
      ack_seen <= 1'b0;
      rdata    <= '0;
    end else if (drop) begin
      wb_cyc_o <= 1'b0;
      wb_stb_o <= 1'b0;
      ack_seen <= 1'b0;
    end else if (launch) begin
      wb_cyc_o <= 1'b1;
      wb_stb_o <= 1'b1;
      wb_we_o  <= launch_we;
      wb_adr_o <= launch_adr;
      if (launch_we) wb_dat_o <= launch_dat;
      ack_seen <= 1'b0;
    end else if (wb_cyc_o && wb_ack_i) begin
      wb_cyc_o <= 1'b0;
      wb_stb_o <= 1'b0;
      ack_seen <= 1'b1;
      if (!wb_we_o) rdata <= wb_dat_i;
    end
  end

endmodule

// File: rtl/spi_wb_bridge.sv
module spi_wb_bridge #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 16,
  parameter int ACK_BITS    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              wb_cyc_o,
  output logic              wb_stb_o,
  output logic              wb_we_o,
  output logic [ADDR_W-1:0] wb_adr_o,
  output logic [DATA_W-1:0] wb_dat_o,
  input  logic [DATA_W-1:0] wb_dat_i,
  input  logic              wb_ack_i
);

  logic              cs_act;
  logic              sck_rise;
  logic              sck_fall;
  logic              mosi_s;
  logic              launch;
  logic              launch_we;
  logic [ADDR_W-1:0] launch_adr;
  logic [DATA_W-1:0] launch_dat;
  logic              drop;
  logic              ack_seen;
  logic [DATA_W-1:0] rdata;

  spi_wb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .sck     (spi_sck),
    .cs_n    (spi_cs_n),
    .mosi    (spi_mosi),
    .cs_act  (cs_act),
    .sck_rise(sck_rise),
    .sck_fall(sck_fall),
    .mosi_s  (mosi_s)
  );

  spi_wb_frame #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .ACK_BITS(ACK_BITS)
  ) u_frame (
    .clk       (clk),
    .rst       (rst),
    .cs_act    (cs_act),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .mosi_s    (mosi_s),
    .ack_seen  (ack_seen),
    .rdata     (rdata),
    .launch    (launch),
    .launch_we (launch_we),
    .launch_adr(launch_adr),
    .launch_dat(launch_dat),
    .drop      (drop),
    .miso      (spi_miso)
  );

  spi_wb_master #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_master (
    .clk       (clk),
    .rst       (rst),
    .launch    (launch),
    .launch_we (launch_we),
    .launch_adr(launch_adr),
    .launch_dat(launch_dat),
    .drop      (drop),
    .wb_ack_i  (wb_ack_i),
    .wb_dat_i  (wb_dat_i),
    .wb_cyc_o  (wb_cyc_o),
    .wb_stb_o  (wb_stb_o),
    .wb_we_o   (wb_we_o),
    .wb_adr_o  (wb_adr_o),
    .wb_dat_o  (wb_dat_o),
    .ack_seen  (ack_seen),
    .rdata     (rdata)
  );

endmodule

// File: rtl/spi_wb_bridge_chk.sv
module spi_wb_bridge_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_act,
  input logic              sck_fall,
  input logic              spi_miso,
  input logic              wb_cyc_o,
  input logic              wb_stb_o,
  input logic              wb_we_o,
  input logic [ADDR_W-1:0] wb_adr_o,
  input logic [DATA_W-1:0] wb_dat_o,
  input logic              wb_ack_i
);

  p_stb_in_cyc_r11: assert property (@(posedge clk) disable iff (rst)
    wb_stb_o |-> wb_cyc_o);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc_o && !wb_ack_i && cs_act) |=>
      (!wb_cyc_o || ($stable(wb_adr_o) && $stable(wb_dat_o) && $stable(wb_we_o))));

  p_end_on_ack_r11: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc_o && wb_ack_i) |=> !wb_cyc_o);

  p_abort_on_cs_r9: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !wb_cyc_o);

  p_idle_miso_r10: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !spi_miso);

  p_miso_on_fall_r10: assert property (@(posedge clk) disable iff (rst)
    (cs_act && !sck_fall) |=> $stable(spi_miso));

  p_reset_quiet_r12: assert property (@(posedge clk)
    rst |=> (!wb_cyc_o && !spi_miso));

endmodule

bind spi_wb_bridge spi_wb_bridge_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cs_act  (cs_act),
  .sck_fall(sck_fall),
  .spi_miso(spi_miso),
  .wb_cyc_o(wb_cyc_o),
  .wb_stb_o(wb_stb_o),
  .wb_we_o (wb_we_o),
  .wb_adr_o(wb_adr_o),
  .wb_dat_o(wb_dat_o),
  .wb_ack_i(wb_ack_i)
);

// File: tb/spi_wb_bridge_bench.sv
module spi_wb_bridge_bench;

  localparam int H = 10;  // half SCK period in clocks

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sck = 1'b0;
  logic        cs_n = 1'b1;
  logic        mosi = 1'b0;
  logic        miso;
  logic        cyc, stb, we;
  logic [3:0]  adr;
  logic [15:0] dat_o;
  logic [15:0] dat_i = '0;
  logic        ack = 1'b0;

  always #5 clk = ~clk;

  spi_wb_bridge u_spi_wb_bridge (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .wb_cyc_o(cyc), .wb_stb_o(stb), .wb_we_o(we),
    .wb_adr_o(adr), .wb_dat_o(dat_o), .wb_dat_i(dat_i), .wb_ack_i(ack)
  );

  // Register-file slave with programmable latency
  logic [15:0] mem [16];
  int          lat = 0;
  int          cnt = 0;
  int          wr_count = 0;

  initial for (int i = 0; i < 16; i++) mem[i] = '0;

  always @(posedge clk) begin
    ack <= 1'b0;
    if (cyc && stb && !ack) begin
      if (cnt >= lat) begin
        ack <= 1'b1;
        cnt <= 0;
        dat_i <= mem[adr];
        if (we) begin
          mem[adr] <= dat_o;
          wr_count <= wr_count + 1;
        end
      end else begin
        cnt <= cnt + 1;
      end
    end else begin
      cnt <= 0;
    end
  end

  // Scoreboard
  typedef struct {
    string       req;
    logic [18:0] v;   // {ack bits, data}
  } item_t;

  item_t       exp_q[$];
  item_t       act_q[$];
  int          nvec = 0;
  int          nfail = 0;
  logic [15:0] shadow [16];
  int          exp_wr = 0;

  initial for (int i = 0; i < 16; i++) shadow[i] = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    while (act_q.size() > 0 && exp_q.size() > 0) begin
      item_t a;
      item_t e;
      a = act_q.pop_front();
      e = exp_q.pop_front();
      chk(e.req, 32'(a.v), 32'(e.v));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic spi_bits(input logic [63:0] tx, input int n, output logic [63:0] rx);
    rx = '0;
    for (int i = n - 1; i >= 0; i--) begin
      mosi = tx[i];
      tick(H);
      rx = {rx[62:0], miso};
      sck = 1'b1;
      tick(H);
      sck = 1'b0;
    end
  endtask

  task automatic cs_low();
    cs_n = 1'b0;
    tick(H);
  endtask

  task automatic cs_high();
    tick(H);
    cs_n = 1'b1;
    tick(2 * H);
  endtask

  function automatic logic [2:0] ack_for(input int l);
    if (l <= 2)  return 3'b111;
    if (l <= 20) return 3'b011;
    if (l <= 40) return 3'b001;
    return 3'b000;
  endfunction

  task automatic push(input string req, input logic [2:0] ea, input logic [15:0] ed,
                      input logic [2:0] aa, input logic [15:0] ad);
    item_t e;
    item_t a;
    e.req = req; e.v = {ea, ed};
    a.req = req; a.v = {aa, ad};
    exp_q.push_back(e);
    act_q.push_back(a);
  endtask

  task automatic do_write(input string req, input logic [3:0] a, input logic [15:0] d,
                          input logic [2:0] tail);
    logic [63:0] rx;
    logic [2:0]  ea;
    ea = ack_for(lat);
    cs_low();
    spi_bits({40'b0, 1'b1, a, d, tail}, 24, rx);
    cs_high();
    if (ea != 3'b000) begin
      shadow[a] = d;
      exp_wr++;
    end
    push(req, ea, 16'h0, rx[2:0], 16'h0);
  endtask

  task automatic do_read(input string req, input logic [3:0] a);
    logic [63:0] rx;
    logic [2:0]  ea;
    ea = ack_for(lat);
    cs_low();
    spi_bits({40'b0, 1'b0, a, 3'b000, 1'b0, 15'b0}, 24, rx);
    cs_high();
    push(req, ea, (ea != 3'b000) ? shadow[a] : 16'h0, rx[18:16], rx[15:0]);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R12 watchdog: actual running, expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [63:0] rx;
    tick(5);
    chk("R12 reset cyc", 32'(cyc), 0);
    chk("R12 reset miso", 32'(miso), 0);
    rst = 1'b0;
    tick(3);
    chk("R12 after reset stb", 32'(stb), 0);

    // Basic write and read, fast slave
    lat = 0;
    do_write("R1 R4 write fast", 4'd3, 16'hA5C3, 3'b101);
    do_read("R1 R2 read fast", 4'd3);
    chk("R11 cycle closed after ack", 32'(cyc), 0);
    chk("R10 miso idle", 32'(miso), 0);

    // Slower slaves: ack lands in the 2nd and 3rd window
    lat = 18;
    do_write("R4 write ack window 2", 4'd12, 16'h1234, 3'b000);
    do_read("R2 read ack window 2", 4'd12);
    lat = 38;
    do_write("R4 write ack window 3", 4'd9, 16'h8001, 3'b000);
    do_read("R2 read ack window 3", 4'd9);

    // Too slow: write dropped, register unchanged
    lat = 200;
    do_write("R5 write not acked", 4'd3, 16'hFFFF, 3'b000);
    chk("R5 cycle dropped", 32'(cyc), 0);
    do_read("R3 read not acked", 4'd12);
    lat = 0;
    do_read("R5 register unchanged", 4'd3);
    chk("R5 write count", 32'(wr_count), 32'(exp_wr));

    // Burst read with flag set and clear
    cs_low();
    spi_bits({21'b0, 1'b0, 4'd12, 3'b000, 1'b1, 15'b0, 3'b000, 1'b0, 15'b0}, 43, rx);
    cs_high();
    push("R6 burst seg1", 3'b111, shadow[12], rx[37:35], rx[34:19]);
    push("R6 burst seg2", 3'b111, shadow[12], rx[18:16], rx[15:0]);
    cs_low();
    spi_bits({21'b0, 1'b0, 4'd9, 3'b000, 1'b0, 15'b0, 3'b000, 1'b0, 15'b0}, 43, rx);
    cs_high();
    push("R6 no-burst seg1", 3'b111, shadow[9], rx[37:35], rx[34:19]);
    push("R6 no-burst seg2", 3'b000, 16'h0, rx[18:16], rx[15:0]);

    // Burst write: second word's top bits come from the first tail
    begin
      logic [15:0] d1;
      logic [15:0] d2;
      d1 = 16'h0F0F;
      d2 = 16'hC00B;
      cs_low();
      spi_bits({24'b0, 1'b1, 4'd7, d1, d2[15:13], d2[12:0], 3'b011}, 40, rx);
      cs_high();
      push("R7 burst write seg1 ack", 3'b111, 16'h0, rx[18:16], 16'h0);
      push("R7 burst write seg2 ack", 3'b111, 16'h0, rx[2:0], 16'h0);
      shadow[7] = d2;
      exp_wr += 2;
      do_read("R7 burst word assembled", 4'd7);
      chk("R7 two writes issued", 32'(wr_count), 32'(exp_wr));
    end

    // Trailing bits ignored when frame ends
    do_write("R8 single write", 4'd5, 16'h0055, 3'b111);
    do_read("R8 tail ignored", 4'd5);
    chk("R8 one write issued", 32'(wr_count), 32'(exp_wr));

    // Partial write frame aborted
    cs_low();
    spi_bits({52'b0, 1'b1, 4'd5, 7'b1111111}, 12, rx);
    cs_high();
    chk("R9 no write on abort", 32'(wr_count), 32'(exp_wr));
    do_read("R9 frame decodes after abort", 4'd5);

    // Read launch point and abort of an open read
    lat = 200;
    cs_low();
    spi_bits({60'b0, 1'b0, 3'b110}, 4, rx);
    tick(5);
    chk("R2 no cycle before bit 4", 32'(cyc), 0);
    spi_bits({63'b0, 1'b1}, 1, rx);
    chk("R2 read started", 32'({cyc, we, adr}), 32'({1'b1, 1'b0, 4'd13}));
    spi_bits(64'b0, 1, rx);
    chk("R11 address held", 32'(adr), 32'd13);
    cs_n = 1'b1;
    tick(6);
    chk("R9 cycle dropped on cs", 32'(cyc), 0);
    chk("R10 miso low when idle", 32'(miso), 0);
    tick(2 * H);

    lat = 0;
    for (int i = 0; i < 16; i++) chk("R4 register image", 32'(mem[i]), 32'(shadow[i]));

    tick(20);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule